// File: doc/BRIEF.md
# RGB to CMYK Pixel Converter

This block turns one RGB pixel, with 8 bits for each channel, into the four ink components cyan, magenta, yellow and black. It works in three steps. First it complements each colour channel against full scale, which gives the intermediate cyan, magenta and yellow values. Next it takes the grey part common to all three as the smallest of those values. That value is the black component K. Last it removes K from each of the three intermediates. The black ink then prints the shared grey part, and the coloured inks print only what remains.

The pixel arrives with a qualifier and leaves with a matching qualifier. A parameter sets the mode. In the registered mode (the default) the result sits in a single register stage. In the combinational mode the output follows the input directly. In the registered mode the stage loads only on a qualified input, so the last result stays on the output while no new pixel arrives.

Top module: `cmyk_converter`

## Requirements
- R1: `pix_rgb` packs red in bits 23:16, green in bits 15:8 and blue in bits 7:0. `pix_cmyk` packs cyan in bits 31:24, magenta in 23:16, yellow in 15:8 and black in 7:0.
- R2: K is the smallest of (255 - red), (255 - green) and (255 - blue).
- R3: The cyan output is (255 - red) - K, the magenta output is (255 - green) - K, and the yellow output is (255 - blue) - K.
- R4: An RGB input of (5, 55, 55) gives intermediate values (250, 200, 200) and the output C,M,Y,K = (50, 0, 0, 200).
- R5: A white input (all RGB bits set) gives zero on all four outputs.
- R6: A black input (all RGB bits clear) gives K = 255 and C = M = Y = 0.
- R7: When two or three intermediate values tie for the minimum, K equals the tied value and every tied channel outputs 0.
- R8: For every input, at least one of C, M and Y is 0, and no coloured output ever wraps around below zero.
- R9: In registered mode, `cmyk_valid` is high in exactly the cycle after each cycle in which `rgb_valid` is high, and the result for that pixel appears in the same cycle.
- R10: In registered mode, a cycle with `rgb_valid` low leaves `pix_cmyk` unchanged, whatever value `pix_rgb` has.
- R11: While reset is asserted, and after it until the first pixel is taken, `cmyk_valid` is 0 and `pix_cmyk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register stage |
| rst_n | input | 1 | Active-low synchronous reset |
| rgb_valid | input | 1 | Marks `pix_rgb` as a pixel to convert |
| pix_rgb | input | 24 | Input pixel, with red as the upper byte |
| cmyk_valid | output | 1 | Marks `pix_cmyk` as a new result |
| pix_cmyk | output | 32 | Output pixel, with cyan as the upper byte and black as the lower byte |

## Verification
Only the property that ties `cmyk_valid` to the previous `rgb_valid` depends on the behaviour of the driving side. That property needs `rgb_valid` to be a clean level at every clock edge. The bench drives it on the falling edge only, and holds it low throughout reset. The other properties hold for any pixel value, so no value is forbidden. The bench feeds a fixed table that covers white, black, ties and single-channel extremes. It then feeds a swept set of pixels, and it inserts idle cycles that carry different RGB data to test the hold behaviour.

// File: rtl/cmyk_pkg.sv
package cmyk_pkg;
    localparam int unsigned DEF_CH_W  = 8;
    localparam int unsigned NUM_INK   = 3;
    localparam int unsigned NUM_OUT   = NUM_INK + 1;
endpackage

// File: rtl/cmyk_invert.sv
module cmyk_invert #(
    parameter int unsigned W = 8,
    parameter int unsigned N = 3
) (
    input  logic [N-1:0][W-1:0] chan_in,
    output logic [N-1:0][W-1:0] chan_out
);
    localparam logic [W-1:0] FULL = {W{1'b1}};

    for (genvar i = 0; i < N; i++) begin : g_ch
        assign chan_out[i] = FULL - chan_in[i];
    end
endmodule

// File: rtl/cmyk_min3.sv
module cmyk_min3 #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] least
);
    logic          a_le_b;
    logic [W-1:0]  ab_min;
    logic          ab_le_c;

    always_comb begin
        a_le_b  = (a <= b);
        ab_min  = a_le_b ? a : b;
        ab_le_c = (ab_min <= c);
        least   = ab_le_c ? ab_min : c;
    end
endmodule

// File: rtl/cmyk_strip.sv
module cmyk_strip #(
    parameter int unsigned W = 8,
    parameter int unsigned N = 3
) (
    input  logic [N-1:0][W-1:0] chan_in,
    input  logic [W-1:0]        grey,
    output logic [N-1:0][W-1:0] chan_out
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        assign chan_out[i] = chan_in[i] - grey;
    end
endmodule

// File: rtl/cmyk_converter.sv
module cmyk_converter #(
    parameter int unsigned CH_W       = cmyk_pkg::DEF_CH_W,
    parameter bit          REGISTERED = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rgb_valid,
    input  logic [3*CH_W-1:0]   pix_rgb,
    output logic                cmyk_valid,
    output logic [4*CH_W-1:0]   pix_cmyk
);
    localparam int unsigned N_INK = cmyk_pkg::NUM_INK;
    localparam int unsigned OUT_W = cmyk_pkg::NUM_OUT * CH_W;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] px;
    } stage_t;

    // index 2 = red/cyan, 1 = green/magenta, 0 = blue/yellow (R1)
    logic [N_INK-1:0][CH_W-1:0] rgb_ch;
    logic [N_INK-1:0][CH_W-1:0] cmy_ch;
    logic [N_INK-1:0][CH_W-1:0] ink_ch;
    logic [CH_W-1:0]            blk_k;
    logic [OUT_W-1:0]           comb_px;

    assign rgb_ch = pix_rgb;

    cmyk_invert #(.W(CH_W), .N(N_INK)) u_inv (
        .chan_in  (rgb_ch),
        .chan_out (cmy_ch)
    );

    cmyk_min3 #(.W(CH_W)) u_min (
        .a     (cmy_ch[2]),
        .b     (cmy_ch[1]),
        .c     (cmy_ch[0]),
        .least (blk_k)
    );

    cmyk_strip #(.W(CH_W), .N(N_INK)) u_strip (
        .chan_in  (cmy_ch),
        .grey     (blk_k),
        .chan_out (ink_ch)
    );

    assign comb_px = {ink_ch, blk_k};

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = rgb_valid;
        if (rgb_valid) begin
            st_d.px = comb_px;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    if (REGISTERED) begin : g_reg
        assign cmyk_valid = st_q.vld;
        assign pix_cmyk   = st_q.px;

        // R9
        valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rgb_valid |=> cmyk_valid);
        // R9
        valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rgb_valid |=> !cmyk_valid);
        // R10
        hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rgb_valid |=> $stable(pix_cmyk));
        // R5
        white_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rgb_valid && pix_rgb == '1) |=> (pix_cmyk == '0));
    end else begin : g_comb
        assign cmyk_valid = rgb_valid;
        assign pix_cmyk   = comb_px;
    end

    // R2
    k_not_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_valid |-> (blk_k <= cmy_ch[0] && blk_k <= cmy_ch[1] && blk_k <= cmy_ch[2]));
    // R8
    one_ink_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmyk_valid |-> (pix_cmyk[4*CH_W-1:3*CH_W] == '0 ||
                        pix_cmyk[3*CH_W-1:2*CH_W] == '0 ||
                        pix_cmyk[2*CH_W-1:CH_W]   == '0));
    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rgb_valid |-> (ink_ch[0] <= cmy_ch[0] && ink_ch[1] <= cmy_ch[1] && ink_ch[2] <= cmy_ch[2]));
endmodule

// File: tb/tb_cmyk_converter.sv
module tb_cmyk_converter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rgb_valid;
    logic [23:0] pix_rgb;
    logic        cmyk_valid;
    logic [31:0] pix_cmyk;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cmyk_converter dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rgb_valid  (rgb_valid),
        .pix_rgb    (pix_rgb),
        .cmyk_valid (cmyk_valid),
        .pix_cmyk   (pix_cmyk)
    );

    localparam int NV = 8;
    localparam logic [55:0] VEC [NV] = '{
        {24'h053737, 32'h320000C8},  // R4
        {24'hFFFFFF, 32'h00000000},  // R5
        {24'h000000, 32'h000000FF},  // R6
        {24'h0A141E, 32'h140A00E1},  // R3
        {24'h646432, 32'h0000329B},  // R7 two-way tie
        {24'hFF0080, 32'h00FF7F00},  // R2 K zero
        {24'h123456, 32'h442200A9},  // R1 field order
        {24'h808080, 32'h0000007F}   // R7 three-way tie
    };

    function automatic logic [31:0] model(input logic [23:0] p);
        int c, m, y, k;
        c = 255 - int'(p[23:16]);
        m = 255 - int'(p[15:8]);
        y = 255 - int'(p[7:0]);
        k = c;
        if (m < k) k = m;
        if (y < k) k = y;
        return {8'(c - k), 8'(m - k), 8'(y - k), 8'(k)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [23:0] p, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rgb_valid = 1'b1;
        pix_rgb   = p;
        @(negedge clk);
        rgb_valid = 1'b0;
        check({tag, " valid"}, {31'd0, cmyk_valid}, 32'd1);
        check(tag, pix_cmyk, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        rst_n     = 1'b0;
        rgb_valid = 1'b0;
        pix_rgb   = 24'h000000;
        repeat (3) @(negedge clk);
        // R11 during reset
        check("R11 valid in reset", {31'd0, cmyk_valid}, 32'd0);
        check("R11 data in reset", pix_cmyk, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 valid after reset", {31'd0, cmyk_valid}, 32'd0);
        check("R11 data after reset", pix_cmyk, 32'd0);

        for (int i = 0; i < NV; i++) begin
            push(VEC[i][55:32], VEC[i][31:0], "R3 table");
        end

        // R10: idle cycle with new RGB data must not change the output
        held = pix_cmyk;
        @(negedge clk);
        pix_rgb = 24'hFFFFFF;
        @(negedge clk);
        check("R10 hold data", pix_cmyk, held);
        check("R9 idle valid", {31'd0, cmyk_valid}, 32'd0);

        // R9: back-to-back pixels, one result per cycle
        @(negedge clk);
        rgb_valid = 1'b1;
        pix_rgb   = 24'h000000;
        @(negedge clk);
        check("R9 b2b first", pix_cmyk, 32'h000000FF);
        pix_rgb = 24'h053737;
        @(negedge clk);
        check("R9 b2b second", pix_cmyk, 32'h320000C8);
        rgb_valid = 1'b0;
        @(negedge clk);
        check("R9 valid drop", {31'd0, cmyk_valid}, 32'd0);

        // R8 / R2 sweep
        for (int i = 0; i < 300; i++) begin
            logic [23:0] p;
            p = 24'((i * 40503) ^ (i << 13) ^ (i * 7));
            push(p, model(p), "R8 sweep");
            if (pix_cmyk[31:24] != 0 && pix_cmyk[23:16] != 0 && pix_cmyk[15:8] != 0) begin
                check("R8 one ink zero", pix_cmyk, {pix_cmyk[31:8] & 24'h0, pix_cmyk[7:0]});
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule